// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Frame Error Detection

This block turns a serial receive line into characters. A free-running oversampling tick, supplied from outside at a fixed multiple of the bit rate, times every bit. A falling edge on the idle line starts a frame. The start bit is confirmed at its midpoint, and each later bit is sampled at its own midpoint. The bits go into a shift register. When the last stop bit has been sampled, the finished character and its status go to a holding buffer in one cycle.

The character length, the parity mode and the number of stop bits come from static configuration inputs. They may change between frames. The block flags three error types: a wrong parity bit, a stop bit sampled low, and a character lost because the buffer was still full. It also flags a break, meaning a frame whose bits after the start bit were all low. A ready flag, gated by its own enable, gives the interrupt request. One read strobe frees the buffer and clears all status.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, rd_valid, err_parity, err_frame, err_overrun, brk_det and irq are all 0.
- R2: The data length is 7 bits when cfg_len = 0, 8 bits when cfg_len = 1, and 9 bits when cfg_len = 2 or 3. Data bits arrive least significant first. rd_data holds the character right-aligned, with the unused upper bits 0.
- R3: cfg_par selects the parity mode: 1 = even, 2 = odd, 0 or 3 = no parity bit. With parity enabled, err_parity is 1 for a character whose parity bit makes the count of ones in data plus parity odd (even mode) or even (odd mode). With parity disabled, err_parity stays 0.
- R4: One stop bit is expected when cfg_two_stop = 0 and two when it is 1. err_frame is 1 for a character in which any expected stop bit was sampled low.
- R5: A low pulse shorter than half a bit period, which reads high at the mid-start sample, produces no character.
- R6: If a frame completes while rd_valid is 1 and no read strobe is given, the new character is discarded. The buffered data and its flags are kept, and err_overrun becomes 1.
- R7: A one-cycle rd_stb clears rd_valid and all four status flags on the next cycle.
- R8: brk_det is 1, together with err_frame, for a character whose data, parity and stop bits were all sampled low.
- R9: irq is 1 exactly when rd_valid is 1 and ready_ie is 1.
- R10: A new frame starts only on a high-to-low transition of the line. A line held low after a break produces no further characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high, asynchronous |
| os_tick | input | 1 | One-cycle oversampling strobe, OSR per bit |
| cfg_len | input | 2 | Character length select |
| cfg_par | input | 2 | Parity mode select |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| ready_ie | input | 1 | Enable for the receive-ready interrupt |
| rd_stb | input | 1 | Read strobe, frees the buffer |
| rd_data | output | 9 | Buffered character, right-aligned |
| rd_valid | output | 1 | Buffer holds an unread character |
| err_parity | output | 1 | Parity error for the buffered character |
| err_frame | output | 1 | Stop bit sampled low |
| err_overrun | output | 1 | A character was lost |
| brk_det | output | 1 | Break frame received |
| irq | output | 1 | Receive-ready interrupt request |

## Verification
The bench builds the block with its defaults: OSR = 16 and a two-stage synchronizer. It delivers one tick every two clocks, so a bit lasts 32 clocks and a full 9-bit frame with parity and two stops fits in a few hundred cycles. That leaves room to sweep all three lengths, both parity senses, both stop counts, the break and glitch cases and the overrun sequence in one run. With 16 ticks per bit, a glitch of three ticks is short of the eight-tick confirmation point. The free-running tick lands at a varying phase against each start edge, so the midpoint sampling is exercised across its allowed offset.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_frame_t;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  function automatic logic [3:0] len_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd7;
      2'd1:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_async,
  output logic rx_level,
  output logic rx_fall
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], rxd_async};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rx_level = chain_q[STAGES-1];
  assign rx_fall  = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx_level,
  input  logic      rx_fall,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic      cfg_two_stop,
  output logic      done,
  output rx_frame_t frame
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [3:0]        idx_q, idx_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              ones_q, ones_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;
  logic              zero_q, zero_d;
  logic              done_q, done_d;
  rx_frame_t         frame_q, frame_d;

  logic [3:0]        nbits;
  logic              par_en;
  logic              mid_bit;
  logic [DATA_W-1:0] aligned;

  assign nbits   = len_bits(cfg_len);
  assign par_en  = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
  assign mid_bit = tick && (cnt_q == FULL_LAST);
  assign aligned = shift_q >> (4'(DATA_W) - nbits);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    ones_d  = ones_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    zero_d  = zero_q;
    done_d  = 1'b0;
    frame_d = frame_q;

    if (tick) begin
      cnt_d = (cnt_q == FULL_LAST) ? '0 : cnt_q + 1'b1;
    end

    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (rx_fall) begin
          state_d = ST_START;
        end
      end
      ST_START: begin
        if (tick && (cnt_q == HALF_LAST)) begin
          if (rx_level) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_DATA;
            cnt_d   = '0;
            idx_d   = '0;
            ones_d  = 1'b0;
            perr_d  = 1'b0;
            ferr_d  = 1'b0;
            zero_d  = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (mid_bit) begin
          shift_d = {rx_level, shift_q[DATA_W-1:1]};
          ones_d  = ones_q ^ rx_level;
          zero_d  = zero_q & ~rx_level;
          idx_d   = idx_q + 4'd1;
          if (idx_q == nbits - 4'd1) begin
            state_d = par_en ? ST_PAR : ST_STOP1;
          end
        end
      end
      ST_PAR: begin
        if (mid_bit) begin
          perr_d  = (ones_q ^ rx_level) != (cfg_par == PAR_ODD);
          zero_d  = zero_q & ~rx_level;
          state_d = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (mid_bit) begin
          ferr_d = ~rx_level;
          zero_d = zero_q & ~rx_level;
          if (cfg_two_stop) begin
            state_d = ST_STOP2;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_STOP2: begin
        if (mid_bit) begin
          ferr_d  = ferr_q | ~rx_level;
          zero_d  = zero_q & ~rx_level;
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (done_d) begin
      frame_d.data = aligned;
      frame_d.perr = perr_d;
      frame_d.ferr = ferr_d;
      frame_d.brk  = zero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      ones_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      ones_q  <= ones_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      zero_q  <= zero_d;
      done_q  <= done_d;
      frame_q <= frame_d;
    end
  end

  assign done  = done_q;
  assign frame = frame_q;

  // R5: a start that reads high at its midpoint returns to idle
  a_r5_glitch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && cnt_q == HALF_LAST && rx_level) |=> (state_q == ST_IDLE));

  // R2: a completion strobe lasts a single cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: the bit index never passes the selected length while data is shifting
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q < nbits));

  // R8: a break character always carries a framing error
  a_r8_break_has_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && frame_q.brk) |-> frame_q.ferr);

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  rx_frame_t         frame_in,
  input  logic              rd_stb,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr,
  output logic              ovr,
  output logic              brk
);

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;
  logic              ovr_q, ovr_d;
  logic              brk_q, brk_d;
  logic              hold;
  logic              accept;

  assign hold   = valid_q & ~rd_stb;
  assign accept = load & ~hold;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    ovr_d   = ovr_q;
    brk_d   = brk_q;
    if (rd_stb) begin
      valid_d = 1'b0;
      perr_d  = 1'b0;
      ferr_d  = 1'b0;
      ovr_d   = 1'b0;
      brk_d   = 1'b0;
    end
    if (accept) begin
      valid_d = 1'b1;
      data_d  = frame_in.data;
      perr_d  = frame_in.perr;
      ferr_d  = frame_in.ferr;
      brk_d   = frame_in.brk;
    end else if (load) begin
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      ovr_q   <= ovr_d;
      brk_q   <= brk_d;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign ovr   = ovr_q;
  assign brk   = brk_q;

  // R6: a character arriving at a full, unread buffer is dropped
  a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid_q && !rd_stb) |=> (ovr_q && valid_q && $stable(data_q)));

  // R7: a read with nothing arriving empties the buffer and its status
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !load) |=> (!valid_q && !ovr_q && !perr_q && !ferr_q && !brk_q));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_two_stop,
  input  logic              ready_ie,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det,
  output logic              irq
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  logic      rx_level;
  logic      rx_fall;
  logic      frame_done;
  rx_frame_t frame_word;

  uart_rx_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rxd_async(rxd),
    .rx_level (rx_level),
    .rx_fall  (rx_fall)
  );

  uart_rx_frame #(
    .OSR(OSR)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .tick        (os_tick),
    .rx_level    (rx_level),
    .rx_fall     (rx_fall),
    .cfg_len     (cfg_len),
    .cfg_par     (cfg_par),
    .cfg_two_stop(cfg_two_stop),
    .done        (frame_done),
    .frame       (frame_word)
  );

  uart_rx_buffer u_buf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (frame_done),
    .frame_in(frame_word),
    .rd_stb  (rd_stb),
    .valid   (rd_valid),
    .data    (rd_data),
    .perr    (err_parity),
    .ferr    (err_frame),
    .ovr     (err_overrun),
    .brk     (brk_det)
  );

  assign irq = rd_valid & ready_ie;

endmodule

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;

  localparam int OSR  = 16;
  localparam int TDIV = 2;
  localparam int BITC = OSR * TDIV;

  logic       clk;
  logic       rst_n;
  logic       rxd;
  logic       os_tick;
  logic [1:0] cfg_len;
  logic [1:0] cfg_par;
  logic       cfg_two_stop;
  logic       ready_ie;
  logic       rd_stb;
  logic [8:0] rd_data;
  logic       rd_valid;
  logic       err_parity;
  logic       err_frame;
  logic       err_overrun;
  logic       brk_det;
  logic       irq;

  int checks;
  int fails;
  bit mon_en;
  bit finished;
  logic [11:0] exp_q[$];

  uart_rx_core #(.OSR(OSR), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
    .ready_ie(ready_ie), .rd_stb(rd_stb), .rd_data(rd_data),
    .rd_valid(rd_valid), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .brk_det(brk_det), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tick_cnt;
  initial begin
    tick_cnt = 0;
    os_tick  = 1'b0;
    forever begin
      @(negedge clk);
      os_tick  = (tick_cnt == TDIV - 1);
      tick_cnt = (tick_cnt == TDIV - 1) ? 0 : tick_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITC) @(negedge clk);
  endtask

  // Driver: builds one frame from the current configuration and queues its expected result
  task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit s1_low,
                            input bit s2_low, input bit push);
    int nb;
    bit par_en;
    logic [8:0] md;
    logic p;
    logic [11:0] e;
    nb     = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd1) ? 8 : 9;
    par_en = (cfg_par == 2'd1) || (cfg_par == 2'd2);
    md     = d & ((9'h1 << nb) - 9'h1);
    p      = (^md) ^ (cfg_par == 2'd2) ^ bad_par;
    e[11:3] = md;
    e[2]    = par_en && bad_par;
    e[1]    = s1_low || (cfg_two_stop && s2_low);
    e[0]    = (md == 9'h0) && (!par_en || !p) && s1_low && (!cfg_two_stop || s2_low);
    if (push) exp_q.push_back(e);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(md[i]);
    if (par_en) drive_bit(p);
    drive_bit(!s1_low);
    if (cfg_two_stop) drive_bit(!s2_low);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
  endtask

  // Monitor: pops expected characters as the buffer fills and reads them out
  initial begin
    logic [11:0] e;
    rd_stb = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_en && rd_valid) begin
        if (exp_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R10 unexpected character actual=%0h expected=none", rd_data);
        end else begin
          e = exp_q.pop_front();
          check("R2 data", {23'd0, rd_data}, {23'd0, e[11:3]});
          check("R3 parity flag", {31'd0, err_parity}, {31'd0, e[2]});
          check("R4 framing flag", {31'd0, err_frame}, {31'd0, e[1]});
          check("R8 break flag", {31'd0, brk_det}, {31'd0, e[0]});
          check("R6 no overrun", {31'd0, err_overrun}, 32'd0);
          check("R9 irq follows enable", {31'd0, irq}, {31'd0, ready_ie});
        end
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0;
    fails = 0;
    finished = 1'b0;
    mon_en = 1'b0;
    rxd = 1'b1;
    cfg_len = 2'd1;
    cfg_par = 2'd0;
    cfg_two_stop = 1'b0;
    ready_ie = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 valid", {31'd0, rd_valid}, 32'd0);
    check("R1 flags", {28'd0, err_parity, err_frame, err_overrun, brk_det}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    mon_en = 1'b1;

    // R2, R9: 8 bits, no parity, one stop
    send_frame(9'h0A5, 0, 0, 0, 1);
    send_frame(9'h03C, 0, 0, 0, 1);
    wait_drain();

    // R2, R3: 7 bits, even parity
    cfg_len = 2'd0; cfg_par = 2'd1;
    send_frame(9'h055, 0, 0, 0, 1);
    send_frame(9'h013, 1, 0, 0, 1);
    wait_drain();

    // R2, R3, R4: 9 bits, odd parity, two stops
    cfg_len = 2'd2; cfg_par = 2'd2; cfg_two_stop = 1'b1;
    send_frame(9'h1A3, 0, 0, 0, 1);
    send_frame(9'h0F0, 1, 0, 0, 1);
    send_frame(9'h101, 0, 0, 1, 1);
    wait_drain();

    // R3: mode 3 means no parity bit; R4: single stop low
    cfg_len = 2'd1; cfg_par = 2'd3; cfg_two_stop = 1'b0;
    send_frame(9'h081, 0, 0, 0, 1);
    send_frame(9'h07E, 0, 1, 0, 1);
    wait_drain();

    // R9: interrupt masked while a character is held
    ready_ie = 1'b0;
    send_frame(9'h0C3, 0, 0, 0, 1);
    wait_drain();
    ready_ie = 1'b1;

    // R8, R10: break with even parity, line held low afterwards
    cfg_par = 2'd1;
    rxd = 1'b0;
    begin
      logic [11:0] e;
      e = {9'h000, 1'b0, 1'b1, 1'b1};
      exp_q.push_back(e);
    end
    repeat (BITC * 14) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC * 3) @(negedge clk);
    wait_drain();
    check("R10 no extra character", {31'd0, rd_valid}, 32'd0);

    // R5: short low pulse
    cfg_par = 2'd0;
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC * 12) @(negedge clk);
    check("R5 glitch ignored", {31'd0, rd_valid}, 32'd0);
    send_frame(9'h05A, 0, 0, 0, 1);
    wait_drain();

    // R6, R7: overrun with the monitor paused
    mon_en = 1'b0;
    send_frame(9'h0A1, 0, 0, 0, 0);
    send_frame(9'h0B2, 0, 1, 0, 0);
    check("R6 held data kept", {23'd0, rd_data}, 32'h0A1);
    check("R6 overrun flag", {31'd0, err_overrun}, 32'd1);
    check("R6 held flags kept", {30'd0, err_frame, rd_valid}, 32'd1);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R7 valid cleared", {31'd0, rd_valid}, 32'd0);
    check("R7 flags cleared", {28'd0, err_parity, err_frame, err_overrun, brk_det}, 32'd0);
    check("R7 irq cleared", {31'd0, irq}, 32'd0);
    mon_en = 1'b1;

    send_frame(9'h0E7, 0, 0, 0, 1);
    wait_drain();

    finish_run();
  end

endmodule